// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a system against software that stops running. A free-running counter advances on enable ticks taken from one of four tick inputs. When the count reaches a power-of-two limit chosen by a 3-bit code, the block either asks for a system reset (watchdog mode) or sets an interrupt flag and starts the count again (interval mode). Software keeps the watchdog quiet by writing the clear command often enough.

All writes on the register bus must carry a fixed key in the upper byte. A write with any other key is treated as runaway code, and the block requests a reset. The reset request is a one-cycle pulse. During that cycle the block also returns all of its own state to the power-up values. After power-up the timer is already armed in watchdog mode, so software that never touches it still gets a timeout.

The bus is a plain single-cycle register port: a write completes on the clock edge where `bus_sel` and `bus_wr` are both high, and `bus_rdata` always shows the register picked by `bus_addr`. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure. The tick inputs are single-cycle enables that are already synchronous to `clk`. Parameter `CNT_W` (default 32) sets the counter width.

Top module: `wdg_keyed_timer`

## Requirements
- R1: After reset, reading address 0 returns 0x6904. This means watchdog mode, not held, tick source 0 and interval code 4. `rst_req` and `irq` are low. At CNT_W=16, the 128th source-0 tick raises `rst_req`.
- R2: A write whose bits 15:8 equal 0x5A updates the fields at address 0: hold at bit 7, source at 6:5, mode at 4 and interval code at 2:0. Bits 15:8 always read 0x69, whatever was written.
- R3: A write to either address whose bits 15:8 differ from 0x5A leaves the register unchanged. It drives `rst_req` high in the cycle after the write edge.
- R4: While hold (bit 7) is 1, ticks do not advance the counter, and the count is kept. Counting resumes from the kept value when hold returns to 0.
- R5: Source code 0, 1, 2 and 3 selects `tick_main`, `tick_aux`, `tick_vlo` and `tick_ext` respectively. Ticks on the other inputs are ignored.
- R6: With CNT_W=32, interval codes 0 to 7 expire after 2^31, 2^27, 2^23, 2^19, 2^15, 2^13, 2^9 and 2^6 ticks. For another width, each exponent is scaled by CNT_W/32 (rounded down and clamped to 1..CNT_W-1), which keeps the same ordering. At CNT_W=16 the limits are 32768, 8192, 2048, 512, 128, 64, 16 and 8.
- R7: In watchdog mode (bit 4 = 0), the expiring tick drives `rst_req` high in the next cycle.
- R8: In interval mode (bit 4 = 1), the expiring tick sets `irq`, restarts the count from zero and raises no reset request.
- R9: A keyed write to address 1 with bit 0 set clears `irq`. Address 1 reads `irq` at bit 0. If an expiry and a clear land on the same edge, the flag ends up set.
- R10: A keyed write to address 0 with bit 3 set zeroes the counter, and the clear takes priority over a tick on the same edge. Bit 3 always reads 0.
- R11: `rst_req` is high for exactly one cycle. Once it has been high, the configuration, counter and `irq` are back at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 1 | 0 = control register, 1 = status register |
| bus_wdata | input | 16 | Write data, key in bits 15:8 |
| bus_rdata | output | 16 | Read data of the addressed register |
| tick_main | input | 1 | Tick source 0 |
| tick_aux | input | 1 | Tick source 1 |
| tick_vlo | input | 1 | Tick source 2 |
| tick_ext | input | 1 | Tick source 3 |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interval expiry flag |

## Verification
The assertions assume that the tick inputs are clean single-cycle enables that are synchronous to `clk`. They also assume that a bus write completes in a single cycle, with no wait states. The bench drives every input on the falling edge and holds each write for exactly one rising edge. Ticks go high only on the selected line, or on a line it means to be ignored. Tick runs are placed between writes, with one exception: the same-edge expiry-and-clear case is deliberately driven in a single cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] KEY_WR   = 8'h5A;
  localparam logic [7:0] KEY_RD   = 8'h69;
  localparam int         NSRC     = 4;
  localparam int         NTAP     = 8;
  localparam int         REF_W    = 32;
  localparam int         CLR_BIT  = 3;

  typedef struct packed {
    logic       hold;
    logic [1:0] src;
    logic       intv;
    logic [2:0] code;
  } wdg_cfg_t;

  localparam wdg_cfg_t CFG_RST = '{hold: 1'b0, src: 2'd0, intv: 1'b0, code: 3'd4};

  // tap exponent at the reference width, then scaled to the actual counter width
  function automatic int tap_exp(input int code, input int cnt_w);
    int base;
    int e;
    case (code)
      0: base = 31;
      1: base = 27;
      2: base = 23;
      3: base = 19;
      4: base = 15;
      5: base = 13;
      6: base = 9;
      default: base = 6;
    endcase
    e = (base * cnt_w) / REF_W;
    if (e < 1) e = 1;
    if (e > cnt_w - 1) e = cnt_w - 1;
    return e;
  endfunction
endpackage

// File: rtl/wdg_tick_sel.sv
module wdg_tick_sel
  import wdg_pkg::*;
(
  input  logic [NSRC-1:0] ticks,
  input  logic [1:0]      src,
  output logic            tick
);
  assign tick = ticks[src];
endmodule

// File: rtl/wdg_tap_counter.sv
module wdg_tap_counter
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       tick,
  input  logic       hold,
  input  logic       clr,
  input  logic [2:0] code,
  output logic       expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1 [NTAP];
  logic [CNT_W-1:0] one;
  logic             at_lim;
  logic             step;

  assign one = {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int TAP_E = tap_exp(g, CNT_W);
    assign lim_m1[g] = (one << TAP_E) - one;
  end

  assign step   = tick & ~hold;
  assign at_lim = (cnt >= lim_m1[code]);
  assign expire = step & ~clr & at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (srst | clr) cnt <= '0;
    else if (step)       cnt <= at_lim ? '0 : cnt + one;
  end

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !clr && !srst |=> $stable(cnt)); // R4
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R10
  AST_EXPIRE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == '0); // R8
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        expire,
  output wdg_cfg_t    cfg,
  output logic        cnt_clr,
  output logic        irq,
  output logic        rst_req
);
  logic wr_any, wr_ok, wr_bad, flag_clr;

  assign wr_any   = bus_sel & bus_wr;
  assign wr_ok    = wr_any & (bus_wdata[15:8] == KEY_WR);
  assign wr_bad   = wr_any & (bus_wdata[15:8] != KEY_WR);
  assign cnt_clr  = wr_ok & ~bus_addr & bus_wdata[CLR_BIT];
  assign flag_clr = wr_ok & bus_addr & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= CFG_RST;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else if (rst_req) begin
      cfg     <= CFG_RST;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr_ok && !bus_addr) begin
        cfg.hold <= bus_wdata[7];
        cfg.src  <= bus_wdata[6:5];
        cfg.intv <= bus_wdata[4];
        cfg.code <= bus_wdata[2:0];
      end
      rst_req <= wr_bad | (expire & ~cfg.intv);
      if (expire && cfg.intv) irq <= 1'b1;
      else if (flag_clr)      irq <= 1'b0;
    end
  end

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad && !rst_req |=> rst_req); // R3
  AST_WDOG_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !cfg.intv && !rst_req |=> rst_req); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire && cfg.intv && !rst_req |=> irq); // R8
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !expire && !rst_req |=> !irq); // R9
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req && !irq && cfg == CFG_RST); // R11
endmodule

// File: rtl/wdg_keyed_timer.sv
module wdg_keyed_timer
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        tick_main,
  input  logic        tick_aux,
  input  logic        tick_vlo,
  input  logic        tick_ext,
  output logic        rst_req,
  output logic        irq
);
  wdg_cfg_t cfg;
  logic     cnt_clr, expire, tick;

  wdg_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expire(expire),
    .cfg(cfg), .cnt_clr(cnt_clr), .irq(irq), .rst_req(rst_req)
  );

  wdg_tick_sel u_sel (
    .ticks({tick_ext, tick_vlo, tick_aux, tick_main}),
    .src(cfg.src), .tick(tick)
  );

  wdg_tap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .srst(rst_req), .tick(tick),
    .hold(cfg.hold), .clr(cnt_clr), .code(cfg.code), .expire(expire)
  );

  assign bus_rdata = bus_addr ? {15'd0, irq}
                              : {KEY_RD, cfg.hold, cfg.src, cfg.intv, 1'b0, cfg.code};

  AST_RDATA_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> bus_rdata[15:8] == KEY_RD && !bus_rdata[CLR_BIT]); // R2
endmodule

// File: tb/wdg_keyed_timer_test.sv
`timescale 1ns/1ps
module wdg_keyed_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  tk = '0;
  logic        rst_req, irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wdg_keyed_timer #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_main(tk[0]), .tick_aux(tk[1]), .tick_vlo(tk[2]), .tick_ext(tk[3]),
    .rst_req(rst_req), .irq(irq)
  );

  localparam logic [2:0] VEC_CODE [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam int         VEC_LIM  [8] = '{32768, 8192, 2048, 512, 128, 64, 16, 8};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 1'b0;
  endtask

  task automatic ticks(input int src, input int n);
    if (n > 0) begin
      @(negedge clk);
      tk[src] = 1'b1;
      repeat (n) @(negedge clk);
      tk = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, d); chk("R1 ctrl reset", d, 16'h6904);
    rd(1'b1, d); chk("R1 status reset", d, 0);
    chk("R1 rst_req low", rst_req, 0);
    ticks(0, 127); chk("R1 default no fire", rst_req, 0);
    ticks(0, 1);   chk("R1 default fires at 128", rst_req, 1);
    @(negedge clk); chk("R11 pulse one cycle", rst_req, 0);

    // R6 R8 table walk: interval mode, each code
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, 16'h5A18 | {13'd0, VEC_CODE[i]});
      ticks(0, VEC_LIM[i] - 1); chk("R6 before limit", irq, 0);
      ticks(0, 1);              chk("R6 at limit", irq, 1);
      chk("R8 no reset in interval", rst_req, 0);
      wr(1'b1, 16'h5A01);       chk("R9 flag cleared", irq, 0);
    end

    // R8 counting restarts after expiry
    wr(1'b0, 16'h5A1F);
    ticks(0, 8); chk("R8 first expiry", irq, 1);
    wr(1'b1, 16'h5A01);
    ticks(0, 7); chk("R8 restart not yet", irq, 0);
    ticks(0, 1); chk("R8 second expiry", irq, 1);
    wr(1'b1, 16'h5A01);

    // R2 keyed write and read-back
    wr(1'b0, 16'h5A9F);
    rd(1'b0, d); chk("R2 readback key and fields", d, 16'h6997);

    // R3 bad key: register unchanged, reset request next cycle
    wr(1'b0, 16'h1234);
    chk("R3 rst_req after bad key", rst_req, 1);
    rd(1'b0, d); chk("R3 register unchanged", d, 16'h6997);
    @(negedge clk);
    chk("R11 rst_req drops", rst_req, 0);
    rd(1'b0, d); chk("R11 config back to reset", d, 16'h6904);

    // R3 bad key on status address
    wr(1'b1, 16'hA501); chk("R3 bad key status addr", rst_req, 1);
    @(negedge clk);

    // R7 watchdog expiry
    wr(1'b0, 16'h5A0F);
    ticks(0, 7); chk("R7 before limit", rst_req, 0);
    ticks(0, 1); chk("R7 fires", rst_req, 1);
    chk("R7 no irq", irq, 0);
    @(negedge clk);
    chk("R11 single cycle", rst_req, 0);
    rd(1'b0, d); chk("R11 reset config", d, 16'h6904);

    // R4 hold keeps the count
    wr(1'b0, 16'h5A1F);
    ticks(0, 5);
    wr(1'b0, 16'h5A97);
    ticks(0, 20); chk("R4 held no expiry", irq, 0);
    wr(1'b0, 16'h5A17);
    ticks(0, 2); chk("R4 resumed not yet", irq, 0);
    ticks(0, 1); chk("R4 resumed from kept value", irq, 1);
    wr(1'b1, 16'h5A01);

    // R5 source selection
    for (int s = 0; s < 4; s++) begin
      wr(1'b0, 16'h5A1F | 16'(s << 5));
      for (int o = 0; o < 4; o++)
        if (o != s) ticks(o, 20);
      chk("R5 other sources ignored", irq, 0);
      ticks(s, 7); chk("R5 selected not yet", irq, 0);
      ticks(s, 1); chk("R5 selected expires", irq, 1);
      wr(1'b1, 16'h5A01);
    end

    // R10 counter clear
    wr(1'b0, 16'h5A17);
    ticks(0, 5);
    wr(1'b0, 16'h5A1F);
    rd(1'b0, d); chk("R10 clear bit reads 0", d, 16'h6917);
    ticks(0, 7); chk("R10 count restarted", irq, 0);
    ticks(0, 1); chk("R10 expiry after clear", irq, 1);
    wr(1'b1, 16'h5A01);
    // R10 clear beats a tick on the same edge
    ticks(0, 7);
    @(negedge clk);
    tk[0] = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 16'h5A1F;
    @(negedge clk);
    tk = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    chk("R10 clear wins over tick", irq, 0);
    ticks(0, 7); chk("R10 zero after same-edge clear", irq, 0);
    ticks(0, 1); chk("R10 expiry after same-edge clear", irq, 1);
    wr(1'b1, 16'h5A01);

    // R9 expiry and clear on the same edge: set wins
    ticks(0, 7);
    @(negedge clk);
    tk[0] = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 16'h5A01;
    @(negedge clk);
    tk = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    chk("R9 set wins over clear", irq, 1);
    rd(1'b1, d); chk("R9 status bit", d, 1);
    wr(1'b1, 16'h5A01); chk("R9 clear after", irq, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule